// File: doc/BRIEF.md
# Three-State Accumulator Processor Core

This block is a small 8-bit accumulator processor that addresses a 16-byte internal RAM with 4-bit addresses. Every instruction passes through three control states. FETCH copies the program counter into the memory address register and advances the counter. DECODE latches the addressed byte into the instruction register and points the address register at the operand. EXECUTE performs the operation.

The datapath holds the program counter, the address register, the RAM, the instruction register, the accumulator with its zero detector, an operand register B, an ALU and an output register. A controller drives the datapath through a compact struct of load strobes.

The RAM is filled through a write port that only acts while reset is held. After reset is released the core runs the program until it reaches a halt instruction. Debug ports expose the control state and every architectural register.

Top module: `accCpuCore`

## Requirements
- R1: While `rst` is high at a clock edge, the PC, MAR, IR, accumulator, B, output register and halted flag all clear to 0, and the state becomes FETCH (code 00).
- R2: The state advances FETCH(00) to DECODE(01) to EXECUTE(10) and back to FETCH. Each non-halting instruction therefore takes exactly three cycles. Code 11 is never held and falls back to FETCH.
- R3: In FETCH the MAR takes the current PC and the PC advances by one, wrapping from 15 to 0. In DECODE the IR takes the RAM byte at the MAR, and the MAR takes that byte's low nibble.
- R4: An instruction byte holds the opcode in bits [7:4] and the address or target in bits [3:0]. The opcodes are: LDA=0, ADD=1, SUB=2, AND=3, OR=4, XOR=5, JMP=6, JZ=7, HLT=F.
- R5: LDA copies RAM[operand] into both the accumulator and the output register. B is left unchanged.
- R6: ADD, SUB, AND, OR and XOR load RAM[operand] into B and combine it with the accumulator (sum and difference taken modulo 256). The result is written to both the accumulator and the output register.
- R7: `dbgZero` is 1 exactly when the accumulator is 0.
- R8: JMP loads the operand into the PC during EXECUTE.
- R9: JZ loads the operand into the PC only when the zero flag is 1. Otherwise the PC keeps its incremented value.
- R10: HLT sets `halted` at the end of its EXECUTE cycle. From then on the state, the PC and all registers hold until reset.
- R11: Opcodes 8 through E do nothing in EXECUTE. The accumulator, B, the output register and the PC are left unchanged.
- R12: `progWe` writes `progData` to RAM[`progAddr`] only while `rst` is high. A write attempted while running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; also enables program loading |
| progWe | input | 1 | RAM write strobe for loading programs |
| progAddr | input | 4 | RAM address for loading |
| progData | input | 8 | RAM write data for loading |
| dataOut | output | 8 | Output register |
| halted | output | 1 | High once HLT has executed |
| dbgState | output | 2 | Control state (00 FETCH, 01 DECODE, 10 EXECUTE) |
| dbgPc | output | 4 | Program counter |
| dbgMar | output | 4 | Memory address register |
| dbgIr | output | 8 | Instruction register |
| dbgAcc | output | 8 | Accumulator |
| dbgB | output | 8 | B operand register |
| dbgZero | output | 1 | Accumulator-is-zero flag |

## Verification
The ALU instructions run on operand pairs chosen so that each operation gives a different answer. The pairs include an addition that wraps past 255, a subtraction that borrows, a subtraction that yields zero, and bit patterns where AND, OR and XOR disagree.

Branch programs run JZ with the accumulator both zero and nonzero, an unconditional JMP, and a loop that passes the PC from 15 to 0. Together these separate a taken branch from a fall-through and show the counter wrapping. Further programs cover an undefined opcode, stepping the core cycle by cycle, freezing after a halt, and a RAM write attempted while running, each showing that nothing else is disturbed.

// File: rtl/accCpuPkg.sv
package accCpuPkg;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 4;
  localparam int OPC_W     = DATA_W - ADDR_W;
  localparam int MEM_DEPTH = 1 << ADDR_W;

  typedef enum logic [1:0] {
    ST_FETCH  = 2'b00,
    ST_DECODE = 2'b01,
    ST_EXEC   = 2'b10
  } cpuState_e;

  typedef enum logic [OPC_W-1:0] {
    OP_LDA = 4'h0,
    OP_ADD = 4'h1,
    OP_SUB = 4'h2,
    OP_AND = 4'h3,
    OP_OR  = 4'h4,
    OP_XOR = 4'h5,
    OP_JMP = 4'h6,
    OP_JZ  = 4'h7,
    OP_HLT = 4'hF
  } opcode_e;

  typedef enum logic [2:0] {
    ALU_PASS,
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_XOR
  } aluOp_e;

  // strobes from the controller to the datapath
  typedef struct packed {
    logic   ldMar;   // MAR <= PC
    logic   incPc;   // PC  <= PC + 1
    logic   ldIr;    // IR  <= mem, MAR <= operand
    logic   ldB;     // B   <= mem
    logic   ldAcc;   // ACC <= ALU result
    logic   ldOut;   // OUT <= ALU result
    logic   ldPc;    // PC  <= IR operand
    aluOp_e aluOp;
  } ctrlStrobe_t;
endpackage

// File: rtl/accCpuAlu.sv
module accCpuAlu
  import accCpuPkg::*;
(
  input  aluOp_e              op,
  input  logic [DATA_W-1:0]   accIn,
  input  logic [DATA_W-1:0]   operand,
  output logic [DATA_W-1:0]   result
);
  always_comb begin
    unique case (op)
      ALU_ADD: result = accIn + operand;
      ALU_SUB: result = accIn - operand;
      ALU_AND: result = accIn & operand;
      ALU_OR:  result = accIn | operand;
      ALU_XOR: result = accIn ^ operand;
      default: result = operand;
    endcase
  end
endmodule

// File: rtl/accCpuCtrl.sv
module accCpuCtrl
  import accCpuPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [OPC_W-1:0]  opcode,
  input  logic              zeroFlag,
  output ctrlStrobe_t       ctrl,
  output logic [1:0]        stateOut,
  output logic              halted
);
  cpuState_e stateQ;
  logic      haltQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= ST_FETCH;
      haltQ  <= 1'b0;
    end else if (!haltQ) begin
      unique case (stateQ)
        ST_FETCH:  stateQ <= ST_DECODE;
        ST_DECODE: stateQ <= ST_EXEC;
        ST_EXEC: begin
          if (opcode_e'(opcode) == OP_HLT) haltQ  <= 1'b1;
          else                             stateQ <= ST_FETCH;
        end
        default:   stateQ <= ST_FETCH;
      endcase
    end
  end

  always_comb begin
    ctrl = '0;
    ctrl.aluOp = ALU_PASS;
    if (!haltQ) begin
      unique case (stateQ)
        ST_FETCH: begin
          ctrl.ldMar = 1'b1;
          ctrl.incPc = 1'b1;
        end
        ST_DECODE: ctrl.ldIr = 1'b1;
        ST_EXEC: begin
          case (opcode_e'(opcode))
            OP_LDA: begin
              ctrl.ldAcc = 1'b1;
              ctrl.ldOut = 1'b1;
            end
            OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR: begin
              ctrl.ldB   = 1'b1;
              ctrl.ldAcc = 1'b1;
              ctrl.ldOut = 1'b1;
              unique case (opcode_e'(opcode))
                OP_ADD:  ctrl.aluOp = ALU_ADD;
                OP_SUB:  ctrl.aluOp = ALU_SUB;
                OP_AND:  ctrl.aluOp = ALU_AND;
                OP_OR:   ctrl.aluOp = ALU_OR;
                default: ctrl.aluOp = ALU_XOR;
              endcase
            end
            OP_JMP:  ctrl.ldPc = 1'b1;
            OP_JZ:   ctrl.ldPc = zeroFlag;
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

  assign stateOut = stateQ;
  assign halted   = haltQ;
endmodule

// File: rtl/accCpuDatapath.sv
module accCpuDatapath
  import accCpuPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobe_t       ctrl,
  input  logic              progWe,
  input  logic [ADDR_W-1:0] progAddr,
  input  logic [DATA_W-1:0] progData,
  output logic [OPC_W-1:0]  opcode,
  output logic              zeroFlag,
  output logic [DATA_W-1:0] dataOut,
  output logic [ADDR_W-1:0] pcOut,
  output logic [ADDR_W-1:0] marOut,
  output logic [DATA_W-1:0] irOut,
  output logic [DATA_W-1:0] accOut,
  output logic [DATA_W-1:0] bOut
);
  logic [DATA_W-1:0] mem [MEM_DEPTH];
  logic [ADDR_W-1:0] pcQ, marQ;
  logic [DATA_W-1:0] irQ, accQ, bQ, outQ;
  logic [DATA_W-1:0] memData, aluRes;

  // program loading is only accepted while the core is held in reset
  always_ff @(posedge clk) begin
    if (rst && progWe) mem[progAddr] <= progData;
  end

  assign memData = mem[marQ];

  accCpuAlu u_alu (
    .op      (ctrl.aluOp),
    .accIn   (accQ),
    .operand (memData),
    .result  (aluRes)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pcQ  <= '0;
      marQ <= '0;
      irQ  <= '0;
      accQ <= '0;
      bQ   <= '0;
      outQ <= '0;
    end else begin
      if (ctrl.ldPc)       pcQ <= irQ[ADDR_W-1:0];
      else if (ctrl.incPc) pcQ <= pcQ + 1'b1;

      if (ctrl.ldMar)      marQ <= pcQ;
      else if (ctrl.ldIr)  marQ <= memData[ADDR_W-1:0];

      if (ctrl.ldIr)  irQ  <= memData;
      if (ctrl.ldB)   bQ   <= memData;
      if (ctrl.ldAcc) accQ <= aluRes;
      if (ctrl.ldOut) outQ <= aluRes;
    end
  end

  assign opcode   = irQ[DATA_W-1:ADDR_W];
  assign zeroFlag = (accQ == '0);
  assign dataOut  = outQ;
  assign pcOut    = pcQ;
  assign marOut   = marQ;
  assign irOut    = irQ;
  assign accOut   = accQ;
  assign bOut     = bQ;
endmodule

// File: rtl/accCpuCore.sv
module accCpuCore
  import accCpuPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              progWe,
  input  logic [ADDR_W-1:0] progAddr,
  input  logic [DATA_W-1:0] progData,
  output logic [DATA_W-1:0] dataOut,
  output logic              halted,
  output logic [1:0]        dbgState,
  output logic [ADDR_W-1:0] dbgPc,
  output logic [ADDR_W-1:0] dbgMar,
  output logic [DATA_W-1:0] dbgIr,
  output logic [DATA_W-1:0] dbgAcc,
  output logic [DATA_W-1:0] dbgB,
  output logic              dbgZero
);
  ctrlStrobe_t      ctrl;
  logic [OPC_W-1:0] opcode;
  logic             zeroFlag;

  accCpuCtrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .opcode   (opcode),
    .zeroFlag (zeroFlag),
    .ctrl     (ctrl),
    .stateOut (dbgState),
    .halted   (halted)
  );

  accCpuDatapath u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .progWe   (progWe),
    .progAddr (progAddr),
    .progData (progData),
    .opcode   (opcode),
    .zeroFlag (zeroFlag),
    .dataOut  (dataOut),
    .pcOut    (dbgPc),
    .marOut   (dbgMar),
    .irOut    (dbgIr),
    .accOut   (dbgAcc),
    .bOut     (dbgB)
  );

  assign dbgZero = zeroFlag;
endmodule

// File: rtl/accCpuCore_chk.sv
module accCpuCore_chk
  import accCpuPkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              halted,
  input logic [1:0]        dbgState,
  input logic [ADDR_W-1:0] dbgPc,
  input logic [ADDR_W-1:0] dbgMar,
  input logic [DATA_W-1:0] dbgIr,
  input logic [DATA_W-1:0] dataOut,
  input logic              dbgZero
);
  // R2: the unused state code never appears
  p_state_legal_r2: assert property (@(posedge clk) disable iff (rst)
    dbgState != 2'b11);

  // R2: fetch is followed by decode, decode by execute
  p_fetch_seq_r2: assert property (@(posedge clk) disable iff (rst)
    (dbgState == 2'b00 && !halted) |=> dbgState == 2'b01);
  p_decode_seq_r2: assert property (@(posedge clk) disable iff (rst)
    (dbgState == 2'b01 && !halted) |=> dbgState == 2'b10);
  p_exec_seq_r2: assert property (@(posedge clk) disable iff (rst)
    (dbgState == 2'b10) |=> (dbgState == 2'b00 || halted));

  // R3: fetch copies PC into MAR and advances PC
  p_fetch_pc_r3: assert property (@(posedge clk) disable iff (rst)
    (dbgState == 2'b00 && !halted) |=>
      (dbgMar == $past(dbgPc)) && (dbgPc == $past(dbgPc) + 1'b1));

  // R5 / R6: the output register changes only after an execute cycle
  p_out_stable_r6: assert property (@(posedge clk) disable iff (rst)
    (dbgState != 2'b10) |=> $stable(dataOut));

  // R8: jump loads the target
  p_jmp_r8: assert property (@(posedge clk) disable iff (rst)
    (dbgState == 2'b10 && dbgIr[7:4] == 4'h6) |=> dbgPc == $past(dbgIr[3:0]));

  // R9: a JZ with a nonzero accumulator leaves the PC alone
  p_jz_fall_r9: assert property (@(posedge clk) disable iff (rst)
    (dbgState == 2'b10 && dbgIr[7:4] == 4'h7 && !dbgZero) |=> $stable(dbgPc));

  // R10: once halted, everything holds
  p_halt_freeze_r10: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted && $stable(dbgPc) && $stable(dbgState) && $stable(dataOut));
endmodule

bind accCpuCore accCpuCore_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .halted   (halted),
  .dbgState (dbgState),
  .dbgPc    (dbgPc),
  .dbgMar   (dbgMar),
  .dbgIr    (dbgIr),
  .dataOut  (dataOut),
  .dbgZero  (dbgZero)
);

// File: tb/accCpuCore_tb.sv
module accCpuCore_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       progWe = 1'b0;
  logic [3:0] progAddr = '0;
  logic [7:0] progData = '0;
  logic [7:0] dataOut, dbgIr, dbgAcc, dbgB;
  logic [3:0] dbgPc, dbgMar;
  logic [1:0] dbgState;
  logic       halted, dbgZero;

  int nChecks = 0;
  int nFails  = 0;
  logic [7:0] prog [16];

  always #5 clk = ~clk;

  accCpuCore u_dut (
    .clk(clk), .rst(rst), .progWe(progWe), .progAddr(progAddr), .progData(progData),
    .dataOut(dataOut), .halted(halted), .dbgState(dbgState), .dbgPc(dbgPc),
    .dbgMar(dbgMar), .dbgIr(dbgIr), .dbgAcc(dbgAcc), .dbgB(dbgB), .dbgZero(dbgZero)
  );

  typedef struct packed {
    logic [3:0] op;
    logic [7:0] a;
    logic [7:0] b;
    logic [7:0] res;
    logic [7:0] expB;
  } vec_t;

  // R6 / R5 operand pairs: program is LDA 14; op 15; HLT
  localparam vec_t VECS [8] = '{
    '{4'h1, 8'd3,   8'd4,   8'd7,   8'd4},
    '{4'h1, 8'd200, 8'd100, 8'd44,  8'd100},
    '{4'h2, 8'd5,   8'd7,   8'd254, 8'd7},
    '{4'h2, 8'd9,   8'd9,   8'd0,   8'd9},
    '{4'h3, 8'hF0,  8'h3C,  8'h30,  8'h3C},
    '{4'h4, 8'hF0,  8'h0F,  8'hFF,  8'h0F},
    '{4'h5, 8'hAA,  8'hFF,  8'h55,  8'hFF},
    '{4'h0, 8'h12,  8'h34,  8'h34,  8'h00}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clearProg();
    for (int i = 0; i < 16; i++) prog[i] = 8'h00;
  endtask

  // loads prog[] while in reset, leaves reset asserted
  task automatic loadProg();
    rst = 1'b1;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      progWe = 1'b1; progAddr = 4'(i); progData = prog[i];
    end
    @(negedge clk);
    progWe = 1'b0;
    @(negedge clk);
  endtask

  task automatic runToHalt(output int cyc);
    @(negedge clk);
    rst = 1'b0;
    cyc = 0;
    while (!halted && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    #1_000_000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    int cyc;
    // ---------------- table walk: ALU and LDA
    for (int v = 0; v < 8; v++) begin
      clearProg();
      prog[0] = 8'h0E;
      prog[1] = {VECS[v].op, 4'hF};
      prog[2] = 8'hF0;
      prog[14] = VECS[v].a;
      prog[15] = VECS[v].b;
      loadProg();
      runToHalt(cyc);
      check("R6", "dataOut", dataOut, VECS[v].res);
      check("R6", "acc", dbgAcc, VECS[v].res);
      check("R6", "B", dbgB, VECS[v].expB);
      check("R7", "zero", dbgZero, VECS[v].res == 8'd0);
      check("R10", "halted", halted, 1'b1);
      if (v == 0) check("R2", "cycles to halt", cyc, 9);
    end

    // ---------------- R1: reset after a run clears everything
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1", "state", dbgState, 2'b00);
    check("R1", "pc", dbgPc, 0);
    check("R1", "mar", dbgMar, 0);
    check("R1", "ir", dbgIr, 0);
    check("R1", "acc", dbgAcc, 0);
    check("R1", "B", dbgB, 0);
    check("R1", "out", dataOut, 0);
    check("R1", "halted", halted, 0);

    // ---------------- R2/R3/R4: step the first instruction
    clearProg();
    prog[0] = 8'h0E; prog[1] = 8'hF0; prog[14] = 8'h5A;
    loadProg();
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R2", "state after 1", dbgState, 2'b01);
    check("R3", "pc after fetch", dbgPc, 1);
    check("R3", "mar after fetch", dbgMar, 0);
    @(negedge clk);
    check("R2", "state after 2", dbgState, 2'b10);
    check("R4", "ir after decode", dbgIr, 8'h0E);
    check("R3", "mar after decode", dbgMar, 4'hE);
    @(negedge clk);
    check("R2", "state after 3", dbgState, 2'b00);
    check("R5", "LDA out", dataOut, 8'h5A);
    check("R5", "LDA B untouched", dbgB, 8'h00);

    // ---------------- R9: JZ taken
    clearProg();
    prog[0] = 8'h0E; prog[1] = 8'h74; prog[2] = 8'h0F; prog[3] = 8'hF0;
    prog[4] = 8'h0D; prog[5] = 8'hF0;
    prog[13] = 8'h22; prog[14] = 8'h00; prog[15] = 8'h11;
    loadProg(); runToHalt(cyc);
    check("R9", "JZ taken out", dataOut, 8'h22);
    // ---------------- R9: JZ not taken
    prog[14] = 8'h05;
    loadProg(); runToHalt(cyc);
    check("R9", "JZ fall-through out", dataOut, 8'h11);
    check("R9", "JZ fall-through pc", dbgPc, 4);

    // ---------------- R8: JMP
    clearProg();
    prog[0] = 8'h63; prog[1] = 8'h0F; prog[2] = 8'hF0;
    prog[3] = 8'h0D; prog[4] = 8'hF0;
    prog[13] = 8'h22; prog[15] = 8'h11;
    loadProg(); runToHalt(cyc);
    check("R8", "JMP out", dataOut, 8'h22);
    check("R8", "JMP pc", dbgPc, 5);

    // ---------------- R3: PC wrap 15 -> 0 (JZ 15; at 15 LDA 13; back to 0)
    clearProg();
    prog[0] = 8'h7F; prog[1] = 8'hF0; prog[13] = 8'h44; prog[15] = 8'h0D;
    loadProg(); runToHalt(cyc);
    check("R3", "wrap out", dataOut, 8'h44);
    check("R3", "wrap pc", dbgPc, 2);

    // ---------------- R11: undefined opcode is a no-op
    clearProg();
    prog[0] = 8'h0E; prog[1] = 8'h9F; prog[2] = 8'hF0;
    prog[14] = 8'h05; prog[15] = 8'h77;
    loadProg(); runToHalt(cyc);
    check("R11", "acc", dbgAcc, 8'h05);
    check("R11", "out", dataOut, 8'h05);
    check("R11", "B", dbgB, 8'h00);
    check("R11", "pc", dbgPc, 3);

    // ---------------- R10: freeze after halt
    repeat (10) @(negedge clk);
    check("R10", "state frozen", dbgState, 2'b10);
    check("R10", "pc frozen", dbgPc, 3);
    check("R10", "out frozen", dataOut, 8'h05);

    // ---------------- R12: write while running is ignored
    progWe = 1'b1; progAddr = 4'hE; progData = 8'h99;
    @(negedge clk);
    progWe = 1'b0;
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    runToHalt(cyc);
    check("R12", "RAM unchanged", dataOut, 8'h05);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule